// File: doc/BRIEF.md
# Light-Load Burst Controller

This block governs the low-power burst regime of a quasi-resonant flyback controller. In normal operation it only watches. When the regulation loop shows a very light load for a sustained period, it takes over the gate and switches it in short packets at a fixed frequency. The analog comparators, the power stage and the normal valley-switching modulator stay outside. The block sees single-bit, clock-synchronous comparator flags and the valley-count setting used by the normal modulator.

Entry needs three things together. The feedback must be below the entry level, the valley setting must sit at its highest value, and both must hold without a break for a qualification window of `QUAL_CYCLES` clocks. Inside burst mode, a hysteretic band enables switching when feedback climbs past the burst-on level. It disables switching when feedback drops to the burst-off level. While switching is enabled, a free-running phase counter of `PERIOD_CYCLES` clocks turns the gate on at the start of each period. The gate turns off at the first of two events: the burst current-limit flag, or half the period. A feedback level above the leave threshold ends burst mode at once, and the block sends a one-cycle request to force the valley counter back to 1. While burst mode is active, the block raises a mask that disables the overload, over-temperature and shorted-winding protections.

Top module: `lb_burst_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `burst_on`, `sw_enable`, `gate_drv`, `valley_to_one` and `prot_mask` are all 0.
- R2: From normal mode, `burst_on` goes to 1 at the clock edge that ends the `QUAL_CYCLES`-th consecutive cycle in which `fb_lt_entry` is 1 and `valley_set` equals `ENTRY_VALLEY` (7). It is still 0 after `QUAL_CYCLES`-1 such cycles.
- R3: One cycle in which either entry condition fails restarts the qualification count from zero. After such a break, `QUAL_CYCLES` further consecutive qualifying cycles are needed.
- R4: With `valley_set` at any value other than 7, burst mode is never entered, whatever `fb_lt_entry` does.
- R5: In burst mode, `sw_enable` rises one edge after `fb_gt_on` is seen. It keeps its value while neither band flag is set, and it falls one edge after `fb_le_off` is seen while `fb_gt_on` is 0. If both flags are set, `fb_gt_on` wins.
- R6: While `sw_enable` is 1 and no trip occurs, `gate_drv` repeats with a period of `PERIOD_CYCLES` clocks. It is high for the first `PERIOD_CYCLES/2` cycles of each period, and the first period starts on the cycle in which `sw_enable` first reads 1.
- R7: If `cs_burst_trip` is 1 in a cycle where `gate_drv` is 1, the gate is low from the next cycle to the end of that period. The next period starts high again.
- R8: In burst mode, `fb_gt_leave` clears `burst_on` and `sw_enable` at the next edge. At that same edge `valley_to_one` goes to 1, for exactly one cycle.
- R9: `prot_mask` equals `burst_on`. `gate_drv` and `sw_enable` are 0 whenever `burst_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_lt_entry | input | 1 | Feedback below the entry level |
| fb_gt_on | input | 1 | Feedback above the burst-on level |
| fb_le_off | input | 1 | Feedback at or below the burst-off level |
| fb_gt_leave | input | 1 | Feedback above the leave level |
| valley_set | input | VALLEY_W | Current valley-count setting of the normal modulator |
| cs_burst_trip | input | 1 | Current sense at the burst peak limit |
| burst_on | output | 1 | Burst mode active |
| sw_enable | output | 1 | Bias enabled, burst switching allowed |
| gate_drv | output | 1 | Burst-mode gate drive |
| valley_to_one | output | 1 | One-cycle request to set the valley counter to 1 |
| prot_mask | output | 1 | Masks overload, over-temperature and shorted-winding protections |

## Verification
The assertions assume that every flag input is already synchronous to `clk` and is stable through the edge that samples it. They also assume that the current-sense flag only matters while the gate is high. There is no data path, so no valid/ready rules apply. The bench changes each input only on falling clock edges. It holds the band flags as single-cycle or level pulses that follow the feedback ordering, and it never asserts the leave flag outside burst mode except as a check that nothing happens.

// File: rtl/lb_burst_pkg.sv
package lb_burst_pkg;
  // Synchronous feedback comparator levels, ordered low to high.
  typedef struct packed {
    logic lt_entry;
    logic le_off;
    logic gt_on;
    logic gt_leave;
  } fb_flags_t;

  // Hysteretic band decision for the next bias state.
  typedef enum logic [1:0] {
    BAND_HOLD = 2'd0,
    BAND_RISE = 2'd1,
    BAND_DROP = 2'd2,
    BAND_KILL = 2'd3
  } band_act_t;
endpackage

// File: rtl/lb_entry_qual.sv
module lb_entry_qual #(
  parameter int QUAL_CYCLES = 240000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic cond_ok,
  output logic qual_hit
);
  localparam int CW = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] run_cnt;

  // Counts qualifying cycles already seen before the current one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!armed || !cond_ok) begin
      run_cnt <= '0;
    end else if (run_cnt != LAST) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign qual_hit = armed && cond_ok && (run_cnt == LAST);
endmodule

// File: rtl/lb_band.sv
module lb_band
  import lb_burst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      burst_q,
  input  fb_flags_t fb,
  output logic      sw_en
);
  band_act_t act;

  always_comb begin
    if (!burst_q || fb.gt_leave) act = BAND_KILL;
    else if (fb.gt_on)           act = BAND_RISE;
    else if (fb.le_off)          act = BAND_DROP;
    else                         act = BAND_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en <= 1'b0;
    end else begin
      unique case (act)
        BAND_RISE: sw_en <= 1'b1;
        BAND_DROP: sw_en <= 1'b0;
        BAND_KILL: sw_en <= 1'b0;
        default:   sw_en <= sw_en;
      endcase
    end
  end
endmodule

// File: rtl/lb_burst_pwm.sv
module lb_burst_pwm #(
  parameter int PERIOD_CYCLES = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_en,
  input  logic cs_trip,
  output logic gate
);
  localparam int PW = $clog2(PERIOD_CYCLES);
  localparam logic [PW-1:0] LAST_PH = PW'(PERIOD_CYCLES - 1);
  localparam logic [PW-1:0] HALF_PH = PW'(PERIOD_CYCLES / 2);

  logic [PW-1:0] phase;
  logic          trip_q;
  logic          wrap;

  assign wrap = (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!sw_en) begin
      phase <= '0;
    end else begin
      phase <= wrap ? '0 : phase + 1'b1;
    end
  end

  // Current-limit latch: holds the gate off until the period restarts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
    end else if (!sw_en || wrap) begin
      trip_q <= 1'b0;
    end else if (gate && cs_trip) begin
      trip_q <= 1'b1;
    end
  end

  assign gate = sw_en && (phase < HALF_PH) && !trip_q;
endmodule

// File: rtl/lb_burst_ctrl.sv
module lb_burst_ctrl
  import lb_burst_pkg::*;
#(
  parameter int QUAL_CYCLES   = 240000,
  parameter int PERIOD_CYCLES = 192,
  parameter int VALLEY_W      = 3,
  parameter int ENTRY_VALLEY  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fb_lt_entry,
  input  logic                fb_gt_on,
  input  logic                fb_le_off,
  input  logic                fb_gt_leave,
  input  logic [VALLEY_W-1:0] valley_set,
  input  logic                cs_burst_trip,
  output logic                burst_on,
  output logic                sw_enable,
  output logic                gate_drv,
  output logic                valley_to_one,
  output logic                prot_mask
);
  localparam logic [VALLEY_W-1:0] ENTRY_V = VALLEY_W'(ENTRY_VALLEY);

  fb_flags_t fb;
  logic      cond_ok;
  logic      qual_hit;
  logic      burst_q;
  logic      force_q;

  assign fb.lt_entry = fb_lt_entry;
  assign fb.le_off   = fb_le_off;
  assign fb.gt_on    = fb_gt_on;
  assign fb.gt_leave = fb_gt_leave;

  assign cond_ok = fb.lt_entry && (valley_set == ENTRY_V);

  lb_entry_qual #(.QUAL_CYCLES(QUAL_CYCLES)) qual_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (!burst_q),
    .cond_ok  (cond_ok),
    .qual_hit (qual_hit)
  );

  // Mode register: leaving has priority, entry only from normal mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      force_q <= 1'b0;
    end else begin
      force_q <= 1'b0;
      if (burst_q && fb.gt_leave) begin
        burst_q <= 1'b0;
        force_q <= 1'b1;
      end else if (qual_hit) begin
        burst_q <= 1'b1;
      end
    end
  end

  lb_band band_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .burst_q (burst_q),
    .fb      (fb),
    .sw_en   (sw_enable)
  );

  lb_burst_pwm #(.PERIOD_CYCLES(PERIOD_CYCLES)) pwm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_en   (sw_enable),
    .cs_trip (cs_burst_trip),
    .gate    (gate_drv)
  );

  assign burst_on      = burst_q;
  assign valley_to_one = force_q;
  assign prot_mask     = burst_q;
endmodule

// File: rtl/lb_burst_ctrl_chk.sv
module lb_burst_ctrl_chk #(
  parameter int VALLEY_W     = 3,
  parameter int ENTRY_VALLEY = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fb_lt_entry,
  input logic                fb_gt_on,
  input logic                fb_le_off,
  input logic                fb_gt_leave,
  input logic [VALLEY_W-1:0] valley_set,
  input logic                cs_burst_trip,
  input logic                burst_on,
  input logic                sw_enable,
  input logic                gate_drv,
  input logic                valley_to_one,
  input logic                prot_mask
);
  assert_entry_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_on) |-> $past(fb_lt_entry && (valley_set == VALLEY_W'(ENTRY_VALLEY))));

  assert_band_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && fb_gt_on && !fb_gt_leave) |=> sw_enable);

  assert_band_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && fb_le_off && !fb_gt_on) |=> !sw_enable);

  assert_gate_needs_bias_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_drv |-> sw_enable);

  assert_trip_cuts_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_drv && cs_burst_trip) |=> !gate_drv);

  assert_leave_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && fb_gt_leave) |=> (!burst_on && valley_to_one && !sw_enable));

  assert_force_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valley_to_one |=> !valley_to_one);

  assert_force_after_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valley_to_one |-> $past(burst_on));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_on |-> (!gate_drv && !sw_enable && !prot_mask));
endmodule

bind lb_burst_ctrl lb_burst_ctrl_chk #(
  .VALLEY_W     (VALLEY_W),
  .ENTRY_VALLEY (ENTRY_VALLEY)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .fb_lt_entry   (fb_lt_entry),
  .fb_gt_on      (fb_gt_on),
  .fb_le_off     (fb_le_off),
  .fb_gt_leave   (fb_gt_leave),
  .valley_set    (valley_set),
  .cs_burst_trip (cs_burst_trip),
  .burst_on      (burst_on),
  .sw_enable     (sw_enable),
  .gate_drv      (gate_drv),
  .valley_to_one (valley_to_one),
  .prot_mask     (prot_mask)
);

// File: tb/lb_burst_ctrl_tb_top.sv
module lb_burst_ctrl_tb_top;
  localparam int QUAL  = 6;
  localparam int PER   = 8;
  localparam int HALF  = PER / 2;
  localparam int VW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_lt_entry = 1'b0, fb_gt_on = 1'b0, fb_le_off = 1'b0, fb_gt_leave = 1'b0;
  logic [VW-1:0] valley_set = '0;
  logic cs_burst_trip = 1'b0;
  logic burst_on, sw_enable, gate_drv, valley_to_one, prot_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lb_burst_ctrl #(
    .QUAL_CYCLES(QUAL), .PERIOD_CYCLES(PER), .VALLEY_W(VW), .ENTRY_VALLEY(7)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .fb_lt_entry(fb_lt_entry), .fb_gt_on(fb_gt_on), .fb_le_off(fb_le_off),
    .fb_gt_leave(fb_gt_leave), .valley_set(valley_set), .cs_burst_trip(cs_burst_trip),
    .burst_on(burst_on), .sw_enable(sw_enable), .gate_drv(gate_drv),
    .valley_to_one(valley_to_one), .prot_mask(prot_mask)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enter_burst();
    fb_lt_entry = 1'b1; valley_set = 3'd7;
    tick(QUAL);
    fb_lt_entry = 1'b0;
  endtask

  task automatic leave_burst();
    fb_gt_leave = 1'b1; tick(1); fb_gt_leave = 1'b0;
    tick(1);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int h;
    tick(3);
    check("R1 reset burst", burst_on, 0);
    check("R1 reset gate", gate_drv, 0);
    rst_n = 1'b1;
    tick(1);
    check("R1 post-reset outputs", {burst_on, sw_enable, gate_drv, valley_to_one, prot_mask}, 0);

    // R4: every non-7 valley value, condition held long
    for (int v = 0; v < 7; v++) begin
      valley_set = VW'(v); fb_lt_entry = 1'b1;
      tick(QUAL + 3);
      check($sformatf("R4 valley %0d no entry", v), burst_on, 0);
    end
    fb_lt_entry = 1'b0; tick(1);

    // R4: leave flag outside burst does nothing
    fb_gt_leave = 1'b1; tick(2); fb_gt_leave = 1'b0;
    check("R4 leave outside burst", {burst_on, valley_to_one}, 0);

    // R2: exact window
    fb_lt_entry = 1'b1; valley_set = 3'd7;
    tick(QUAL - 1);
    check("R2 window minus one", burst_on, 0);
    tick(1);
    check("R2 window complete", burst_on, 1);
    check("R9 mask in burst", prot_mask, 1);
    check("R5 bias off on entry", sw_enable, 0);
    fb_lt_entry = 1'b0;
    leave_burst();

    // R3: break at every position in the window
    for (int b = 1; b < QUAL; b++) begin
      fb_lt_entry = 1'b1; valley_set = 3'd7;
      tick(b);
      if (b % 2 == 0) fb_lt_entry = 1'b0; else valley_set = 3'd6;
      tick(1);
      fb_lt_entry = 1'b1; valley_set = 3'd7;
      tick(QUAL - 1);
      check($sformatf("R3 break at %0d early", b), burst_on, 0);
      tick(1);
      check($sformatf("R3 break at %0d entry", b), burst_on, 1);
      fb_lt_entry = 1'b0;
      leave_burst();
    end

    // R5/R6: band and free-running period
    enter_burst();
    fb_gt_on = 1'b1; tick(1); fb_gt_on = 1'b0;
    check("R5 rise on flag", sw_enable, 1);
    for (int i = 0; i < 2 * PER; i++) begin
      check($sformatf("R6 gate phase %0d", i % PER), gate_drv, ((i % PER) < HALF) ? 1 : 0);
      tick(1);
    end
    check("R5 hold in band", sw_enable, 1);
    fb_le_off = 1'b1; fb_gt_on = 1'b1; tick(1); fb_gt_on = 1'b0;
    check("R5 on wins over off", sw_enable, 1);
    tick(1); fb_le_off = 1'b0;
    check("R5 drop on off flag", sw_enable, 0);
    check("R5 gate low after drop", gate_drv, 0);

    // R7: trip at each on-phase
    for (int k = 0; k < HALF; k++) begin
      fb_gt_on = 1'b1; tick(1); fb_gt_on = 1'b0;
      h = 0;
      for (int i = 0; i < PER; i++) begin
        h += int'(gate_drv);
        cs_burst_trip = (i == k);
        tick(1);
        cs_burst_trip = 1'b0;
      end
      check($sformatf("R7 trip at %0d high time", k), h, k + 1);
      h = 0;
      for (int i = 0; i < PER; i++) begin
        h += int'(gate_drv);
        tick(1);
      end
      check($sformatf("R7 trip at %0d next period", k), h, HALF);
      fb_le_off = 1'b1; tick(1); fb_le_off = 1'b0;
    end

    // R8: exit while switching
    fb_gt_on = 1'b1; tick(1); fb_gt_on = 1'b0;
    fb_gt_leave = 1'b1; tick(1); fb_gt_leave = 1'b0;
    check("R8 exit burst", burst_on, 0);
    check("R8 force pulse", valley_to_one, 1);
    check("R8 bias cleared", sw_enable, 0);
    check("R9 mask cleared", prot_mask, 0);
    tick(1);
    check("R8 force one cycle", valley_to_one, 0);
    check("R9 gate idle", gate_drv, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule